// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits in a host bridge and holds the configuration address that the CPU programs before a configuration data access. Software selects the target device by setting one IDSEL bit in the upper part of a 32-bit word, not by writing a device number. On a write, the block finds the lowest set IDSEL bit and turns its position into a five-bit device number. It stores that number in an internal bus/device/function/register word, together with an enable flag.

The decoded fields leave the block as separate outputs, for a configuration data window elsewhere in the bridge. When the CPU reads the address back, the block rebuilds the one-hot IDSEL form from the stored device number. A byte-order input selects whether CPU words are byte-swapped on both the write and the read path.

The block also maps a slot's interrupt pin to a line. It rotates the pin by the device number, modulo four, and adds a fixed base to give the input number at the interrupt controller.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset, `cfg_enable` is 0, the bus, device, function and register fields are all 0, and a readback returns 0.
- R2: On a write, the device number is the index of the lowest set bit among data bits 11..31, after any byte swap. Set bits above that one are ignored.
- R3: Data bits 10:8 become the function and data bits 7:2 become the register. Data bits 1:0 are discarded. The bus field is always 0, and bits 0..10 never take part in device selection.
- R4: A write with a set bit in 11..31 sets `cfg_enable`. A write with none of those bits set clears `cfg_enable` and stores device number 0.
- R5: While `rd_en` is high, `rdata` equals the OR of three parts: a one-hot bit at the stored device position (only when enabled), the function in bits 10:8, and the register in bits 7:2. Bits 1:0 read 0. While `rd_en` is low, `rdata` is 0.
- R6: When `big_endian` is 1, the four bytes of the 32-bit word are reversed (byte 0 with byte 3, byte 1 with byte 2). This applies to `wdata` before decoding and to the readback before it drives `rdata`. When it is 0, no swap takes place.
- R7: The stored address changes only on the rising clock edge where `wr_en` is high. In all other cycles it holds, whatever `wdata` does.
- R8: `irq_line` equals (`irq_pin` + `irq_dev`) mod 4, and `irq_num` equals `irq_line` + 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the address register |
| rd_en | input | 1 | Read strobe; gates `rdata` |
| wdata | input | 32 | CPU write data |
| big_endian | input | 1 | 1 = reverse the byte order of CPU words |
| rdata | output | 32 | One-hot readback of the address |
| cfg_enable | output | 1 | Stored address is valid |
| cfg_bus | output | 8 | Bus number (always 0) |
| cfg_dev | output | 5 | Device number |
| cfg_func | output | 3 | Function number |
| cfg_reg | output | 6 | Dword register index |
| irq_dev | input | 5 | Device number for the interrupt mapping |
| irq_pin | input | 2 | Interrupt pin requested by the device (0..3) |
| irq_line | output | 2 | Rotated interrupt line |
| irq_num | output | 8 | Interrupt controller input number |

## Verification
The assertions assume that `wr_en`, `wdata` and `big_endian` are stable around each rising edge. They also assume that `big_endian` does not change between a write and the checks tied to it. The one-hot readback assertion applies only to little-endian reads, because the IDSEL bit moves to another byte when the word is swapped. The stimulus changes inputs one time unit after a rising edge and samples on the falling edge. It keeps the byte order fixed within each write and read, except in cases that mix the two orders on purpose and check the result in the bench.

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate #(
  parameter int IDSEL_LO = 11,
  parameter int IRQ_BASE = 8,
  parameter int IRQ_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [31:0]      wdata,
  input  logic             big_endian,
  output logic [31:0]      rdata,
  output logic             cfg_enable,
  output logic [7:0]       cfg_bus,
  output logic [4:0]       cfg_dev,
  output logic [2:0]       cfg_func,
  output logic [5:0]       cfg_reg,
  input  logic [4:0]       irq_dev,
  input  logic [1:0]       irq_pin,
  output logic [1:0]       irq_line,
  output logic [IRQ_W-1:0] irq_num
);
  localparam int DEV_W = 5;

  function automatic logic [31:0] swap32(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  logic [31:0]      wr_sw;
  logic [31:0]      addr_q;
  logic [31:0]      rb_le;
  logic [31:0]      onehot;
  logic             hit;
  logic [DEV_W-1:0] dev_n;

  assign wr_sw = big_endian ? swap32(wdata) : wdata;

  always_comb begin
    hit   = 1'b0;
    dev_n = '0;
    for (int i = 31; i >= IDSEL_LO; i--) begin
      if (wr_sw[i]) begin
        hit   = 1'b1;
        dev_n = DEV_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else if (wr_en)
      addr_q <= {hit, 7'd0, 8'd0, dev_n, wr_sw[10:2], 2'b00};
  end

  assign cfg_enable = addr_q[31];
  assign cfg_bus    = addr_q[23:16];
  assign cfg_dev    = addr_q[15:11];
  assign cfg_func   = addr_q[10:8];
  assign cfg_reg    = addr_q[7:2];

  assign onehot = cfg_enable ? (32'd1 << cfg_dev) : 32'd0;
  assign rb_le  = onehot | {21'd0, cfg_func, cfg_reg, 2'b00};
  assign rdata  = rd_en ? (big_endian ? swap32(rb_le) : rb_le) : 32'd0;

  assign irq_line = irq_pin + irq_dev[1:0];
  assign irq_num  = IRQ_W'(IRQ_BASE) + IRQ_W'(irq_line);

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({cfg_enable, cfg_bus, cfg_dev, cfg_func, cfg_reg})); // R7
  AST_ENABLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_enable == ($past(wr_sw[31:IDSEL_LO]) != '0))); // R4
  AST_EMPTY_DEV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> cfg_dev == '0); // R4
  AST_DEV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_enable |-> cfg_dev >= DEV_W'(IDSEL_LO)); // R2
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sw[IDSEL_LO]) |=> cfg_dev == DEV_W'(IDSEL_LO)); // R2
  AST_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_bus == 8'd0); // R3
  AST_RD_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !big_endian |-> rdata[1:0] == 2'b00); // R5
  AST_ONEHOT_RB: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !big_endian |-> $countones(rdata[31:IDSEL_LO]) == (cfg_enable ? 1 : 0)); // R5
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 32'd0); // R5
  AST_IRQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_num >= IRQ_W'(IRQ_BASE) && irq_num < IRQ_W'(IRQ_BASE + 4)); // R8
endmodule

// File: tb/cfg_addr_xlate_tb.sv
module cfg_addr_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, big_endian = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cfg_enable;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [4:0]  irq_dev = '0;
  logic [1:0]  irq_pin = '0;
  logic [1:0]  irq_line;
  logic [7:0]  irq_num;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_addr_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .big_endian(big_endian), .rdata(rdata), .cfg_enable(cfg_enable),
    .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_reg(cfg_reg),
    .irq_dev(irq_dev), .irq_pin(irq_pin), .irq_line(irq_line), .irq_num(irq_num));

  typedef struct {
    logic [31:0] rd;
    logic        en;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [5:0]  rg;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t last_exp;

  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] d, input bit be_w, input bit be_r, input string tag);
    exp_t e;
    logic [31:0] s, rb;
    s = be_w ? bswap(d) : d;
    e.en = 0; e.dev = 0;
    for (int i = 11; i < 32; i++)
      if (s[i]) begin e.en = 1; e.dev = 5'(i); break; end
    e.fn = s[10:8];
    e.rg = s[7:2];
    rb = (e.en ? (32'd1 << e.dev) : 32'd0) | {21'd0, e.fn, e.rg, 2'b00};
    e.rd = be_r ? bswap(rb) : rb;
    e.tag = tag;
    return e;
  endfunction

  task automatic push_read(input exp_t e, input bit be_r);
    @(posedge clk); #1;
    rd_en = 1; big_endian = be_r;
    sb.push_back(e);
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic wr(input logic [31:0] d, input bit be_w, input bit be_r, input string tag);
    @(posedge clk); #1;
    wr_en = 1; wdata = d; big_endian = be_w;
    @(posedge clk); #1;
    wr_en = 0;
    last_exp = model(d, be_w, be_r, tag);
    rd_en = 1; big_endian = be_r;
    sb.push_back(last_exp);
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  always @(negedge clk) begin
    if (rd_en && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " rdata"}, rdata, e.rd);
      chk({e.tag, " enable"}, 32'(cfg_enable), 32'(e.en));
      chk({e.tag, " dev"}, 32'(cfg_dev), 32'(e.dev));
      chk({e.tag, " func"}, 32'(cfg_func), 32'(e.fn));
      chk({e.tag, " reg"}, 32'(cfg_reg), 32'(e.rg));
      chk({e.tag, " bus"}, 32'(cfg_bus), 32'd0);
    end
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    e = model(32'd0, 0, 0, "R1 reset");
    push_read(e, 0);
    // R5 idle read returns zero
    @(negedge clk);
    chk("R5 idle rdata", rdata, 32'd0);
    // R2 single IDSEL bits across the range
    for (int i = 11; i < 32; i += 4) wr(32'd1 << i, 0, 0, "R2 single");
    wr(32'h8000_0000, 0, 0, "R2 top bit");
    // R2 lowest of several wins
    wr(32'hF00C_8000, 0, 0, "R2 lowest wins");
    wr(32'hFFFF_F800, 0, 0, "R2 all idsel");
    // R3 function/register copy, low bits dropped, low bits no select
    wr(32'h0002_07FF, 0, 0, "R3 fields");
    wr(32'h0000_1503, 0, 0, "R3 func reg");
    // R4 no IDSEL bit
    wr(32'h0000_07FC, 0, 0, "R4 empty");
    chk("R4 empty enable", 32'(cfg_enable), 32'd0);
    // R6 big-endian both paths
    wr(32'h0010_0000, 1, 1, "R6 swap both");
    wr(32'h0C08_0400, 1, 0, "R6 swap write");
    wr(32'h0004_0524, 0, 1, "R6 swap read");
    // R7 hold without write strobe
    wr(32'h0040_0318, 0, 0, "R7 setup");
    @(posedge clk); #1 wdata = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    push_read(last_exp, 0);
    // R8 interrupt swizzle
    for (int d = 0; d < 32; d++)
      for (int p = 0; p < 4; p++) begin
        irq_dev = 5'(d); irq_pin = 2'(p);
        #1;
        chk("R8 line", 32'(irq_line), 32'((p + d) % 4));
        chk("R8 num", 32'(irq_num), 32'(((p + d) % 4) + 8));
      end
    repeat (3) @(posedge clk);
    chk("R5 queue drained", 32'(sb.size()), 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule